// File: doc/BRIEF.md
# Time-Multiplexed Predicated Processing Core

This block is the compute half of one tile in a word-oriented processor array. It has no fetch pipeline and no branches. A small program store holds a static list of instructions, one per slot. While `run` is high the core executes one slot per clock. After the last configured slot it returns to slot 0, which marks the end of one user cycle. A single 32-bit adder and comparator is shared by every slot. Its operands come from several small word files: a 16-word general file, a 16-word exchange file, and four 4-word buffers filled by the north, south, east and west neighbours. A data memory is reached by load and store.

Four predicate bits can guard any instruction. A not-equal compare can write one of these bits. An external bit-level control path can also load them directly, so one-bit control decisions never pass through the 32-bit datapath. A guarded instruction whose predicate bit is clear does nothing. Within a user cycle, slot order encodes the meaning of each value. A value modelling a combinational wire is written in an earlier slot than the slot that reads it. A value modelling a register is read in the same slot that overwrites it, or in an earlier one.

Top module: `pe_core`

## Requirements
- R1: While `rst_n` is low, and until the first run cycle after reset, `slot` is 0, `pred_out` is 0, `io_out` is 0 and `cycle_done` is 0.
- R2: On each clock with `run` high, the instruction stored at `slot` executes and `slot` advances by one. When `slot` equals `last_slot`, `cycle_done` is high and `slot` returns to 0 at the next edge. With `run` low, `slot` holds. A program word is written into slot `prog_addr` on each clock with `prog_we` high. Instruction word bits: [34:32] opcode, [31] guard enable, [30:29] guard index, [28:23] destination, [22:17] source A, [16:11] source B, [10:0] immediate.
- R3: A 6-bit operand field selects a word as follows. Bits [5:4] = 00 selects the general file and 01 selects the exchange file, with the word index in bits [3:0]. Bits [5:4] = 10 selects a neighbour buffer, with the side in bits [3:2] (0 north, 1 south, 2 east, 3 west) and the word in bits [1:0]. Bits [5:4] = 11 reads as zero. Only the general and exchange files can be written as a destination.
- R4: The opcodes are 3 ADD (dst = A + B), 4 ADDI (dst = A + immediate sign-extended from 11 bits), 6 IOLOAD (dst = `io_in`) and 7 IOSTORE (`io_out` takes A at the edge).
- R5: Opcode 1 LOAD writes dst with the data-memory word at the address given by the low bits of A. Opcode 2 STORE writes B into the data memory at the address given by the low bits of A.
- R6: Opcode 5 CMP sets predicate bit dst[1:0] to 1 when A differs from B and to 0 when they are equal.
- R7: When the guard enable is 1 and predicate bit [guard index] is 0, the instruction changes no file, memory, predicate or `io_out`.
- R8: An instruction reads its sources before its own write takes effect. A write made in one slot is visible to every later slot.
- R9: Opcode 0 NOP leaves every file, the data memory, the predicates and `io_out` unchanged.
- R10: At any clock, each predicate bit i with `bit_load[i]` high takes `bit_in[i]`. The load works whether `run` is high or low. When an executing CMP targets the same bit in the same clock, the CMP result wins.
- R11: On a clock with `nbr_we` high, `nbr_data` is written into word `nbr_idx` of the buffer for side `nbr_side`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execute one slot per clock |
| prog_we | input | 1 | Program word write enable |
| prog_addr | input | 4 | Program slot to write |
| prog_word | input | 35 | Instruction word |
| last_slot | input | 4 | Index of the final slot of the user cycle |
| io_in | input | 32 | Word taken by IOLOAD |
| io_out | output | 32 | Word driven by IOSTORE |
| bit_in | input | 4 | Bit-level predicate values |
| bit_load | input | 4 | Per-bit predicate load strobes |
| nbr_we | input | 1 | Neighbour buffer write enable |
| nbr_side | input | 2 | Neighbour side being written |
| nbr_idx | input | 2 | Word within the neighbour buffer |
| nbr_data | input | 32 | Neighbour word |
| pred_out | output | 4 | Current predicate bits |
| slot | output | 4 | Slot executing in this clock |
| cycle_done | output | 1 | High during the final slot of a user cycle |

## Verification
The bench builds the core with 8 slots and a 64-word data memory. Eight slots are enough for every program it runs, the longest being six slots. The small memory lets the pointer FIFO program address memory through the low bits of a general-file word without large arrays. With this build, the bench can drive a full slot wrap and the `cycle_done` pulse, a pause in the middle of a cycle, and a compare and an external predicate load on the same bit in one clock. It also runs a multi-cycle FIFO whose read pointer and write pointer move under separate predicate bits.

// File: rtl/pe_core_pkg.sv
package pe_core_pkg;
  localparam int DATA_W  = 32;
  localparam int OPND_W  = 6;
  localparam int IMM_W   = 11;
  localparam int PRED_N  = 4;
  localparam int PSEL_W  = 2;
  localparam int FILE_D  = 16;
  localparam int NB_SIDES = 4;
  localparam int NB_D    = 4;
  localparam int INSTR_W = 3 + 1 + PSEL_W + 3 * OPND_W + IMM_W;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_LOAD    = 3'd1,
    OP_STORE   = 3'd2,
    OP_ADD     = 3'd3,
    OP_ADDI    = 3'd4,
    OP_CMP     = 3'd5,
    OP_IOLOAD  = 3'd6,
    OP_IOSTORE = 3'd7
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              pen;
    logic [PSEL_W-1:0] psel;
    logic [OPND_W-1:0] dst;
    logic [OPND_W-1:0] srca;
    logic [OPND_W-1:0] srcb;
    logic [IMM_W-1:0]  imm;
  } instr_t;

  localparam logic [1:0] SP_GEN  = 2'd0;
  localparam logic [1:0] SP_XCH  = 2'd1;
  localparam logic [1:0] SP_NBR  = 2'd2;
  localparam logic [1:0] SP_ZERO = 2'd3;
endpackage

// File: rtl/pe_sched.sv
module pe_sched
  import pe_core_pkg::*;
#(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              prog_we,
  input  logic [SLOT_W-1:0] prog_addr,
  input  instr_t            prog_word,
  input  logic [SLOT_W-1:0] last_slot,
  output instr_t            cur,
  output logic [SLOT_W-1:0] slot,
  output logic              wrap
);
  instr_t            prog_mem [SLOTS];
  logic [SLOT_W-1:0] pc_q;
  logic [SLOT_W-1:0] pc_d;

  always_ff @(posedge clk) begin
    if (prog_we) prog_mem[prog_addr] <= prog_word;
  end

  assign wrap = run && (pc_q == last_slot);

  always_comb begin
    pc_d = pc_q;
    if (run) pc_d = wrap ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_d;
  end

  assign cur  = prog_mem[pc_q];
  assign slot = pc_q;
endmodule

// File: rtl/pe_opfile.sv
module pe_opfile
  import pe_core_pkg::*;
(
  input  logic              clk,
  input  logic [OPND_W-1:0] rd_a_sel,
  input  logic [OPND_W-1:0] rd_b_sel,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  input  logic              wr_en,
  input  logic [OPND_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              nb_we,
  input  logic [1:0]        nb_side,
  input  logic [1:0]        nb_idx,
  input  logic [DATA_W-1:0] nb_data
);
  logic [DATA_W-1:0] gen_mem [FILE_D];
  logic [DATA_W-1:0] xch_mem [FILE_D];
  logic [DATA_W-1:0] nb_mem  [NB_SIDES][NB_D];

  logic [OPND_W-1:0] sel [2];
  logic [DATA_W-1:0] val [2];

  assign sel[0] = rd_a_sel;
  assign sel[1] = rd_b_sel;
  assign rd_a   = val[0];
  assign rd_b   = val[1];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      case (sel[p][5:4])
        SP_GEN:  val[p] = gen_mem[sel[p][3:0]];
        SP_XCH:  val[p] = xch_mem[sel[p][3:0]];
        SP_NBR:  val[p] = nb_mem[sel[p][3:2]][sel[p][1:0]];
        default: val[p] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_sel[5:4] == SP_GEN) gen_mem[wr_sel[3:0]] <= wr_data;
    if (wr_en && wr_sel[5:4] == SP_XCH) xch_mem[wr_sel[3:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NB_SIDES; s++) begin
      if (nb_we && nb_side == 2'(s)) nb_mem[s][nb_idx] <= nb_data;
    end
  end
endmodule

// File: rtl/pe_dmem.sv
module pe_dmem
  import pe_core_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/pe_core.sv
module pe_core
  import pe_core_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int DMEM_DEPTH = 2048,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int DA_W      = $clog2(DMEM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               prog_we,
  input  logic [SLOT_W-1:0]  prog_addr,
  input  logic [INSTR_W-1:0] prog_word,
  input  logic [SLOT_W-1:0]  last_slot,
  input  logic [DATA_W-1:0]  io_in,
  output logic [DATA_W-1:0]  io_out,
  input  logic [PRED_N-1:0]  bit_in,
  input  logic [PRED_N-1:0]  bit_load,
  input  logic               nbr_we,
  input  logic [1:0]         nbr_side,
  input  logic [1:0]         nbr_idx,
  input  logic [DATA_W-1:0]  nbr_data,
  output logic [PRED_N-1:0]  pred_out,
  output logic [SLOT_W-1:0]  slot,
  output logic               cycle_done
);
  instr_t            cur;
  logic              wrap;
  logic [DATA_W-1:0] a_val, b_val, dm_rdata;
  logic [DATA_W-1:0] imm_ext;
  logic              active;
  logic              rf_we, dm_we;
  logic [DATA_W-1:0] rf_wdata;
  logic [PRED_N-1:0] pred_q, pred_d;
  logic              pred_en;
  logic [DATA_W-1:0] io_q;
  logic              io_en;

  pe_sched #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .prog_word (instr_t'(prog_word)),
    .last_slot (last_slot),
    .cur       (cur),
    .slot      (slot),
    .wrap      (wrap)
  );

  pe_opfile u_opfile (
    .clk      (clk),
    .rd_a_sel (cur.srca),
    .rd_b_sel (cur.srcb),
    .rd_a     (a_val),
    .rd_b     (b_val),
    .wr_en    (rf_we),
    .wr_sel   (cur.dst),
    .wr_data  (rf_wdata),
    .nb_we    (nbr_we),
    .nb_side  (nbr_side),
    .nb_idx   (nbr_idx),
    .nb_data  (nbr_data)
  );

  pe_dmem #(.DEPTH(DMEM_DEPTH), .AW(DA_W)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .addr  (a_val[DA_W-1:0]),
    .wdata (b_val),
    .rdata (dm_rdata)
  );

  assign imm_ext = {{(DATA_W-IMM_W){cur.imm[IMM_W-1]}}, cur.imm};
  assign active  = run && (!cur.pen || pred_q[cur.psel]);

  always_comb begin
    rf_we    = 1'b0;
    dm_we    = 1'b0;
    rf_wdata = a_val + b_val;
    io_en    = 1'b0;
    pred_d   = pred_q;
    for (int i = 0; i < PRED_N; i++) begin
      if (bit_load[i]) pred_d[i] = bit_in[i];
    end
    if (active) begin
      case (cur.op)
        OP_ADD:     rf_we = 1'b1;
        OP_ADDI: begin
          rf_we    = 1'b1;
          rf_wdata = a_val + imm_ext;
        end
        OP_LOAD: begin
          rf_we    = 1'b1;
          rf_wdata = dm_rdata;
        end
        OP_IOLOAD: begin
          rf_we    = 1'b1;
          rf_wdata = io_in;
        end
        OP_STORE:   dm_we = 1'b1;
        OP_CMP:     pred_d[cur.dst[PSEL_W-1:0]] = (a_val != b_val);
        OP_IOSTORE: io_en = 1'b1;
        default:    ;
      endcase
    end
  end

  assign pred_en = run || (|bit_load);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pred_q <= '0;
    else if (pred_en) pred_q <= pred_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     io_q <= '0;
    else if (io_en) io_q <= a_val;
  end

  assign io_out     = io_q;
  assign pred_out   = pred_q;
  assign cycle_done = wrap;
endmodule

// File: rtl/pe_core_chk.sv
module pe_core_chk #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [3:0]        bit_load,
  input logic [SLOT_W-1:0] slot,
  input logic              cycle_done,
  input logic [3:0]        pred_out,
  input logic [31:0]       io_out,
  input logic [2:0]        op,
  input logic              pen,
  input logic [1:0]        psel
);
  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> (slot == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cycle_done) |=> (slot == SLOT_W'($past(slot) + 1'b1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(slot));

  p_done_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> run);

  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 3'd0 && bit_load == '0) |=> ($stable(pred_out) && $stable(io_out)));

  p_guard_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pen && !pred_out[psel] && bit_load == '0) |=> ($stable(pred_out) && $stable(io_out)));
endmodule

bind pe_core pe_core_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .bit_load   (bit_load),
  .slot       (slot),
  .cycle_done (cycle_done),
  .pred_out   (pred_out),
  .io_out     (io_out),
  .op         (cur.op),
  .pen        (cur.pen),
  .psel       (cur.psel)
);

// File: tb/pe_core_bench.sv
module pe_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 8;
  localparam int DMEM  = 64;
  localparam int SW    = 3;

  localparam logic [2:0] B_NOP = 3'd0, B_LOAD = 3'd1, B_STORE = 3'd2, B_ADD = 3'd3,
                         B_ADDI = 3'd4, B_CMP = 3'd5, B_IOLD = 3'd6, B_IOST = 3'd7;

  // {write enable, write data, read enable}
  localparam logic [33:0] FIFO_VEC [8] = '{
    {1'b1, 32'h0000_00A1, 1'b0},
    {1'b1, 32'h0000_00B2, 1'b0},
    {1'b1, 32'h0000_00C3, 1'b1},
    {1'b0, 32'h0000_0000, 1'b1},
    {1'b1, 32'h0000_00D4, 1'b1},
    {1'b0, 32'h0000_0000, 1'b1},
    {1'b1, 32'h0000_00E5, 1'b0},
    {1'b1, 32'h0000_00F6, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run;
  logic          prog_we;
  logic [SW-1:0] prog_addr;
  logic [34:0]   prog_word;
  logic [SW-1:0] last_slot;
  logic [31:0]   io_in;
  logic [31:0]   io_out;
  logic [3:0]    bit_in, bit_load;
  logic          nbr_we;
  logic [1:0]    nbr_side, nbr_idx;
  logic [31:0]   nbr_data;
  logic [3:0]    pred_out;
  logic [SW-1:0] slot;
  logic          cycle_done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [34:0] pbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  pe_core #(.SLOTS(SLOTS), .DMEM_DEPTH(DMEM)) u_pe_core (
    .clk(clk), .rst_n(rst_n), .run(run), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_word(prog_word), .last_slot(last_slot), .io_in(io_in), .io_out(io_out),
    .bit_in(bit_in), .bit_load(bit_load), .nbr_we(nbr_we), .nbr_side(nbr_side),
    .nbr_idx(nbr_idx), .nbr_data(nbr_data), .pred_out(pred_out), .slot(slot),
    .cycle_done(cycle_done)
  );

  function automatic logic [34:0] mk(input logic [2:0] op, input logic pen, input logic [1:0] ps,
                                     input logic [5:0] d, input logic [5:0] a, input logic [5:0] b,
                                     input logic [10:0] imm);
    return {op, pen, ps, d, a, b, imm};
  endfunction
  function automatic logic [5:0] gr(input int n); return {2'b00, 4'(n)}; endfunction
  function automatic logic [5:0] xr(input int n); return {2'b01, 4'(n)}; endfunction
  function automatic logic [5:0] nb(input int s, input int i); return {2'b10, 2'(s), 2'(i)}; endfunction
  localparam logic [5:0] ZR = 6'b110000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_prog(input int n);
    for (int i = 0; i < n; i++) begin
      prog_we = 1'b1; prog_addr = SW'(i); prog_word = pbuf[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
    last_slot = SW'(n - 1);
  endtask

  task automatic run_n(input int n);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] model [16];
    int wp, rp;
    logic [31:0] exp_out;
    rst_n = 1'b0; run = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_word = '0;
    last_slot = '0; io_in = '0; bit_in = '0; bit_load = '0;
    nbr_we = 1'b0; nbr_side = '0; nbr_idx = '0; nbr_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 slot", 32'(slot), 0);
    chk("R1 pred_out", 32'(pred_out), 0);
    chk("R1 io_out", io_out, 0);
    chk("R1 cycle_done", 32'(cycle_done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // clear FIFO pointers R0, R1
    pbuf[0] = mk(B_IOLD, 0, 0, gr(0), ZR, ZR, 0);
    pbuf[1] = mk(B_IOLD, 0, 0, gr(1), ZR, ZR, 0);
    load_prog(2);
    io_in = 0;
    run_n(2);
    chk("R1 io_out still zero", io_out, 0);

    // R8/R4/R2: wire and register ordering, sign-extended immediate, sequencing
    pbuf[0] = mk(B_IOLD, 0, 0, gr(5), ZR, ZR, 0);
    pbuf[1] = mk(B_ADD,  0, 0, gr(6), gr(5), gr(5), 0);
    pbuf[2] = mk(B_ADD,  0, 0, gr(5), gr(5), gr(6), 0);
    pbuf[3] = mk(B_IOST, 0, 0, ZR, gr(5), ZR, 0);
    pbuf[4] = mk(B_ADDI, 0, 0, gr(7), gr(5), ZR, 11'h7FD);
    pbuf[5] = mk(B_IOST, 0, 0, ZR, gr(7), ZR, 0);
    load_prog(6);
    io_in = 32'd10;
    run_n(3);
    chk("R2 slot after three steps", 32'(slot), 3);
    repeat (2) @(negedge clk);
    chk("R2 slot holds with run low", 32'(slot), 3);
    chk("R2 io_out holds with run low", io_out, 0);
    run_n(1);
    chk("R8 write-before-read and read-before-write", io_out, 32'd30);
    run = 1'b1;
    @(negedge clk);
    chk("R2 slot at last", 32'(slot), 5);
    chk("R2 cycle_done in last slot", 32'(cycle_done), 1);
    @(negedge clk);
    run = 1'b0;
    chk("R2 wrap to slot 0", 32'(slot), 0);
    chk("R4 ADDI sign-extended", io_out, 32'd27);

    // R11/R3: neighbour buffers and exchange file
    nbr_we = 1'b1; nbr_side = 2'd2; nbr_idx = 2'd2; nbr_data = 32'h100;
    @(negedge clk);
    nbr_side = 2'd3; nbr_idx = 2'd0; nbr_data = 32'h5;
    @(negedge clk);
    nbr_we = 1'b0;
    pbuf[0] = mk(B_IOLD, 0, 0, xr(3), ZR, ZR, 0);
    pbuf[1] = mk(B_ADD,  0, 0, gr(4), xr(3), nb(2, 2), 0);
    pbuf[2] = mk(B_ADD,  0, 0, gr(9), gr(4), nb(3, 0), 0);
    pbuf[3] = mk(B_IOST, 0, 0, ZR, gr(9), ZR, 0);
    load_prog(4);
    io_in = 32'd7;
    run_n(4);
    chk("R11 R3 neighbour and exchange operands", io_out, 32'h10C);

    // R6/R7: compare and guarded instructions (R5=30, R6=20, R7=27)
    pbuf[0] = mk(B_CMP,  0, 0, 6'd2, gr(5), gr(6), 0);
    pbuf[1] = mk(B_CMP,  0, 0, 6'd3, gr(5), gr(5), 0);
    pbuf[2] = mk(B_ADD,  1, 3, gr(7), gr(5), gr(5), 0);
    pbuf[3] = mk(B_IOST, 1, 3, ZR, gr(5), ZR, 0);
    pbuf[4] = mk(B_ADD,  1, 2, gr(7), gr(7), gr(6), 0);
    pbuf[5] = mk(B_IOST, 1, 2, ZR, gr(7), ZR, 0);
    load_prog(6);
    run_n(4);
    chk("R6 compare sets and clears", 32'(pred_out), 32'b0100);
    chk("R7 guarded IOSTORE suppressed", io_out, 32'h10C);
    run_n(2);
    chk("R7 guarded ADD suppressed, enabled ADD runs", io_out, 32'd47);

    // R9: NOP slots
    for (int i = 0; i < 4; i++) pbuf[i] = mk(B_NOP, 0, 0, gr(7), gr(5), gr(5), 0);
    load_prog(4);
    run_n(4);
    chk("R9 NOP keeps predicates", 32'(pred_out), 32'b0100);
    pbuf[0] = mk(B_IOST, 0, 0, ZR, gr(7), ZR, 0);
    load_prog(1);
    run_n(1);
    chk("R9 NOP keeps general file", io_out, 32'd47);

    // R10: external predicate load and compare priority
    bit_in = 4'b0011; bit_load = 4'b1011;
    @(negedge clk);
    bit_load = 4'b0000;
    chk("R10 bit load with run low", 32'(pred_out), 32'b0111);
    pbuf[0] = mk(B_CMP, 0, 0, 6'd0, gr(5), gr(5), 0);
    load_prog(1);
    bit_in = 4'b0001; bit_load = 4'b0001;
    run_n(1);
    bit_load = 4'b0000;
    chk("R10 compare wins over bit load", 32'(pred_out), 32'b0110);

    // R5/R7: pointer FIFO under predicates p0 (write) and p1 (read)
    pbuf[0] = mk(B_LOAD, 1, 1, gr(3), gr(1), ZR, 0);
    pbuf[1] = mk(B_IOST, 1, 1, ZR, gr(3), ZR, 0);
    pbuf[2] = mk(B_ADDI, 1, 1, gr(1), gr(1), ZR, 11'd1);
    pbuf[3] = mk(B_IOLD, 1, 0, gr(2), ZR, ZR, 0);
    pbuf[4] = mk(B_STORE, 1, 0, ZR, gr(0), gr(2), 0);
    pbuf[5] = mk(B_ADDI, 1, 0, gr(0), gr(0), ZR, 11'd1);
    load_prog(6);
    wp = 0; rp = 0; exp_out = io_out;
    for (int v = 0; v < 8; v++) begin
      logic we_v, re_v;
      logic [31:0] d_v;
      {we_v, d_v, re_v} = FIFO_VEC[v];
      if (re_v) begin exp_out = model[rp]; rp++; end
      if (we_v) begin model[wp] = d_v; wp++; end
      bit_in = {2'b00, re_v, we_v}; bit_load = 4'b0011;
      @(negedge clk);
      bit_load = 4'b0000;
      io_in = d_v;
      run_n(6);
      chk($sformatf("R5 FIFO step %0d", v), io_out, exp_out);
    end

    finish_run();
  end
endmodule